// File: doc/BRIEF.md
# Single-Channel DMA Transfer Engine

This block is one channel of a DMA controller. Software programs it through a small word-addressed register port: a control byte, a 16-bit transfer count, a peripheral address and a memory address. Once the channel is enabled, each request from the attached peripheral produces one bus transaction pair. The channel first reads one item from the source, then writes that item to the destination. A control bit chooses which address is the source. Either address can advance by one item (4 bytes) after every completed transfer, or it can stay fixed.

The count register decrements after each completed transfer. Software can write it only while the channel is disabled; while the channel runs, a read returns the live remaining count. In circular mode the count and both address pointers reload automatically when the count reaches zero. Half-complete, complete and bus-error events set sticky flags. Software clears these flags by writing ones to them. Each flag drives an interrupt output through its own enable bit. A bus error stops the channel by clearing the enable bit in hardware.

Top module: `dma_channel`

## Requirements
- R1: After reset every register reads zero. Register offsets on `reg_addr` are 0 for control, 1 for count, 2 for peripheral address, 3 for memory address and 4 for flags. The control bits are: bit 0 enable, bit 1 complete-interrupt enable, bit 2 half-interrupt enable, bit 3 error-interrupt enable, bit 4 direction, bit 5 circular, bit 6 peripheral increment and bit 7 memory increment. All control bits read back as written.
- R2: A transfer is a read followed by a write. With direction 0, the read uses the peripheral pointer and the write uses the memory pointer; with direction 1 these are swapped. `bus_req`, `bus_we` and `bus_addr` hold until the cycle in which `bus_gnt` is high. Read data is taken in that cycle, and the write is requested in the next cycle carrying that data.
- R3: Writing enable from 0 to 1 loads both pointers from the programmed addresses. After each completed transfer, a pointer whose increment bit is 1 advances by 4; otherwise it stays unchanged.
- R4: A transfer starts only when enable is 1, the count is nonzero and `periph_req` is 1. `periph_ack` is high for exactly the one cycle in which the write is granted without error.
- R5: Count writes are ignored while enable is 1. Count reads return the live remaining count in bits [15:0], with bits [31:16] reading zero.
- R6: The count decrements by one after each completed transfer.
- R7: In circular mode, the transfer that takes the count to zero instead reloads the last programmed count and both pointers. The channel stays enabled and keeps serving requests.
- R8: In non-circular mode, the count stays at zero after the final transfer and the channel stays enabled. No further bus requests are made.
- R9: When `bus_err` is high in a granted cycle, the transfer is abandoned without decrementing the count. Enable is cleared and the error flag is set.
- R10: The flag register has complete at bit 0, half at bit 1 and error at bit 2. The complete flag sets when the count reaches zero. The half flag sets when the remaining count first falls to half the programmed count or below. Writing a one to a flag bit clears it, and a new event in the same cycle takes precedence. Each interrupt output equals its flag ANDed with its enable bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register word offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, combinational from `reg_addr` |
| periph_req | input | 1 | Peripheral requests a transfer (level) |
| periph_ack | output | 1 | One-cycle pulse when a transfer completes |
| bus_req | output | 1 | Bus transaction request |
| bus_we | output | 1 | 1 for the write phase, 0 for the read phase |
| bus_addr | output | 32 | Bus address |
| bus_wdata | output | 32 | Bus write data |
| bus_rdata | input | 32 | Bus read data, valid with grant |
| bus_gnt | input | 1 | Bus grant, completes the current phase |
| bus_err | input | 1 | Bus error, qualified by grant |
| irq_tc | output | 1 | Transfer-complete interrupt |
| irq_ht | output | 1 | Half-transfer interrupt |
| irq_te | output | 1 | Transfer-error interrupt |

## Verification
The assertions assume the bus grants only while a request is pending and reports an error only with a grant. They also assume software leaves the enable, direction and increment bits alone while a read/write pair is in flight, so that a granted write always finds the channel running. The stimulus keeps within these limits. It drops `periph_req` and waits several idle cycles before any reprogramming. Its bus responder raises grant only in reply to a pending request, after a programmable wait, and injects an error only on a chosen granted address.

// File: rtl/dma_ch_pkg.sv
package dma_ch_pkg;

   typedef enum logic [1:0] {
      XS_IDLE  = 2'd0,
      XS_READ  = 2'd1,
      XS_WRITE = 2'd2
   } xfer_state_e;

   localparam int CTRL_W  = 8;
   localparam int CB_EN   = 0;
   localparam int CB_TCIE = 1;
   localparam int CB_HTIE = 2;
   localparam int CB_TEIE = 3;
   localparam int CB_DIR  = 4;
   localparam int CB_CIRC = 5;
   localparam int CB_PINC = 6;
   localparam int CB_MINC = 7;

   localparam int FLAG_W = 3;
   localparam int FB_TC  = 0;
   localparam int FB_HT  = 1;
   localparam int FB_TE  = 2;

   localparam int REG_AW = 3;
   localparam logic [REG_AW-1:0] RA_CTRL  = 3'd0;
   localparam logic [REG_AW-1:0] RA_COUNT = 3'd1;
   localparam logic [REG_AW-1:0] RA_PADDR = 3'd2;
   localparam logic [REG_AW-1:0] RA_MADDR = 3'd3;
   localparam logic [REG_AW-1:0] RA_FLAGS = 3'd4;

endpackage

// File: rtl/dma_ch_regs.sv
module dma_ch_regs
   import dma_ch_pkg::*;
#(
   parameter int ADDR_W = 32
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                reg_we,
   input  logic [REG_AW-1:0]   reg_addr,
   input  logic [31:0]         reg_wdata,
   input  logic                err_evt,
   input  logic                tc_evt,
   input  logic                ht_evt,
   output logic [CTRL_W-1:0]   ctrl_o,
   output logic [ADDR_W-1:0]   paddr_o,
   output logic [ADDR_W-1:0]   maddr_o,
   output logic [FLAG_W-1:0]   flags_o,
   output logic                en_rise_o,
   output logic                cnt_we_o
);

   logic [CTRL_W-1:0] ctrl_q;
   logic [ADDR_W-1:0] paddr_q, maddr_q;
   logic [FLAG_W-1:0] flags_q, flag_set, flag_clr;

   assign en_rise_o = reg_we && (reg_addr == RA_CTRL) && reg_wdata[CB_EN] && !ctrl_q[CB_EN];
   assign cnt_we_o  = reg_we && (reg_addr == RA_COUNT) && !ctrl_q[CB_EN];

   always_comb begin
      flag_set        = '0;
      flag_set[FB_TC] = tc_evt;
      flag_set[FB_HT] = ht_evt;
      flag_set[FB_TE] = err_evt;
      flag_clr        = (reg_we && reg_addr == RA_FLAGS) ? reg_wdata[FLAG_W-1:0] : '0;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl_q  <= '0;
         paddr_q <= '0;
         maddr_q <= '0;
         flags_q <= '0;
      end else begin
         if (reg_we && reg_addr == RA_CTRL)  ctrl_q  <= reg_wdata[CTRL_W-1:0];
         if (reg_we && reg_addr == RA_PADDR) paddr_q <= reg_wdata[ADDR_W-1:0];
         if (reg_we && reg_addr == RA_MADDR) maddr_q <= reg_wdata[ADDR_W-1:0];
         if (err_evt) ctrl_q[CB_EN] <= 1'b0;
         flags_q <= (flags_q & ~flag_clr) | flag_set;
      end
   end

   assign ctrl_o  = ctrl_q;
   assign paddr_o = paddr_q;
   assign maddr_o = maddr_q;
   assign flags_o = flags_q;

   a_r9_err_drops_en: assert property (@(posedge clk) disable iff (!rst_n)
      err_evt |=> !ctrl_q[CB_EN]);

   a_r10_err_flag: assert property (@(posedge clk) disable iff (!rst_n)
      err_evt |=> flags_q[FB_TE]);

   a_r10_tc_flag: assert property (@(posedge clk) disable iff (!rst_n)
      tc_evt |=> flags_q[FB_TC]);

endmodule

// File: rtl/dma_ch_counter.sv
module dma_ch_counter #(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load_i,
   input  logic [CNT_W-1:0] load_val_i,
   input  logic             done_i,
   input  logic             circ_i,
   output logic [CNT_W-1:0] cnt_o,
   output logic             zero_o,
   output logic             wrap_o,
   output logic             tc_evt_o,
   output logic             ht_evt_o
);

   localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

   logic [CNT_W-1:0] cnt_q, prog_q, cnt_dec;
   logic [CNT_W:0]   twice_now, twice_next, prog_ext;
   logic             last_item;

   assign cnt_dec    = cnt_q - ONE;
   assign last_item  = (cnt_q == ONE);
   assign twice_now  = {cnt_q, 1'b0};
   assign twice_next = {cnt_dec, 1'b0};
   assign prog_ext   = {1'b0, prog_q};

   assign tc_evt_o = done_i && last_item;
   assign wrap_o   = done_i && last_item && circ_i;
   assign ht_evt_o = done_i && (twice_now > prog_ext) && (twice_next <= prog_ext);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q  <= '0;
         prog_q <= '0;
      end else if (load_i) begin
         cnt_q  <= load_val_i;
         prog_q <= load_val_i;
      end else if (wrap_o) begin
         cnt_q  <= prog_q;
      end else if (done_i) begin
         cnt_q  <= cnt_dec;
      end
   end

   assign cnt_o  = cnt_q;
   assign zero_o = (cnt_q == '0);

   a_r6_decrement: assert property (@(posedge clk) disable iff (!rst_n)
      (done_i && !load_i && cnt_q > ONE) |=> (cnt_q == $past(cnt_q) - ONE));

   a_r7_reload: assert property (@(posedge clk) disable iff (!rst_n)
      (done_i && !load_i && circ_i && last_item) |=> (cnt_q == $past(prog_q)));

   a_r8_reach_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (done_i && !load_i && !circ_i && last_item) |=> zero_o);

   a_r6_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (!done_i && !load_i) |=> $stable(cnt_q));

endmodule

// File: rtl/dma_ch_addr_gen.sv
module dma_ch_addr_gen #(
   parameter int ADDR_W = 32,
   parameter int STEP   = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] base_i,
   input  logic              load_i,
   input  logic              wrap_i,
   input  logic              adv_i,
   output logic [ADDR_W-1:0] ptr_o
);

   logic [ADDR_W-1:0] ptr_q;

   generate
      if (STEP == 0) begin : g_fixed
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                 ptr_q <= '0;
            else if (load_i || wrap_i)  ptr_q <= base_i;
         end
      end else begin : g_step
         localparam logic [ADDR_W-1:0] INC = ADDR_W'(STEP);
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                 ptr_q <= '0;
            else if (load_i || wrap_i)  ptr_q <= base_i;
            else if (adv_i)             ptr_q <= ptr_q + INC;
         end

         a_r3_advance: assert property (@(posedge clk) disable iff (!rst_n)
            (adv_i && !load_i && !wrap_i) |=> (ptr_q == $past(ptr_q) + INC));
      end
   endgenerate

   assign ptr_o = ptr_q;

   a_r3_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (!adv_i && !load_i && !wrap_i) |=> $stable(ptr_q));

   a_r3_load: assert property (@(posedge clk) disable iff (!rst_n)
      load_i |=> (ptr_q == $past(base_i)));

endmodule

// File: rtl/dma_ch_xfer_fsm.sv
module dma_ch_xfer_fsm
   import dma_ch_pkg::*;
#(
   parameter int ADDR_W = 32,
   parameter int DATA_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              en_i,
   input  logic              dir_i,
   input  logic              cnt_zero_i,
   input  logic              periph_req,
   input  logic [ADDR_W-1:0] ptr_p_i,
   input  logic [ADDR_W-1:0] ptr_m_i,
   input  logic              bus_gnt,
   input  logic              bus_err,
   input  logic [DATA_W-1:0] bus_rdata,
   output logic              bus_req,
   output logic              bus_we,
   output logic [ADDR_W-1:0] bus_addr,
   output logic [DATA_W-1:0] bus_wdata,
   output logic              done_o,
   output logic              err_o
);

   xfer_state_e       state_q, state_d;
   logic [DATA_W-1:0] data_q;
   logic [ADDR_W-1:0] src_addr, dst_addr;
   logic              start;

   assign start    = (state_q == XS_IDLE) && en_i && !cnt_zero_i && periph_req;
   assign src_addr = dir_i ? ptr_m_i : ptr_p_i;
   assign dst_addr = dir_i ? ptr_p_i : ptr_m_i;

   always_comb begin
      state_d = state_q;
      unique case (state_q)
         XS_IDLE:  if (start) state_d = XS_READ;
         XS_READ:  if (bus_gnt) state_d = bus_err ? XS_IDLE : XS_WRITE;
         XS_WRITE: if (bus_gnt) state_d = XS_IDLE;
         default:  state_d = XS_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= XS_IDLE;
         data_q  <= '0;
      end else begin
         state_q <= state_d;
         if (state_q == XS_READ && bus_gnt && !bus_err) data_q <= bus_rdata;
      end
   end

   assign bus_req   = (state_q != XS_IDLE);
   assign bus_we    = (state_q == XS_WRITE);
   assign bus_addr  = (state_q == XS_WRITE) ? dst_addr : src_addr;
   assign bus_wdata = data_q;
   assign done_o    = (state_q == XS_WRITE) && bus_gnt && !bus_err;
   assign err_o     = (state_q != XS_IDLE) && bus_gnt && bus_err;

   a_r2_hold_request: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_req && !bus_gnt) |=> (bus_req && $stable(bus_we) && $stable(bus_addr)));

   a_r2_write_follows: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_req && !bus_we && bus_gnt && !bus_err) |=> (bus_req && bus_we && bus_wdata == $past(bus_rdata)));

   a_r4_single_ack: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> !done_o);

   a_r8_zero_blocks: assert property (@(posedge clk) disable iff (!rst_n)
      (!bus_req && cnt_zero_i) |=> !bus_req);

   a_r9_error_ends: assert property (@(posedge clk) disable iff (!rst_n)
      err_o |=> !bus_req);

endmodule

// File: rtl/dma_channel.sv
module dma_channel
   import dma_ch_pkg::*;
#(
   parameter int ADDR_W     = 32,
   parameter int DATA_W     = 32,
   parameter int CNT_W      = 16,
   parameter int ITEM_BYTES = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_we,
   input  logic [2:0]        reg_addr,
   input  logic [31:0]       reg_wdata,
   output logic [31:0]       reg_rdata,
   input  logic              periph_req,
   output logic              periph_ack,
   output logic              bus_req,
   output logic              bus_we,
   output logic [ADDR_W-1:0] bus_addr,
   output logic [DATA_W-1:0] bus_wdata,
   input  logic [DATA_W-1:0] bus_rdata,
   input  logic              bus_gnt,
   input  logic              bus_err,
   output logic              irq_tc,
   output logic              irq_ht,
   output logic              irq_te
);

   generate
      if (CNT_W < 2 || CNT_W > 32) begin : g_bad_cnt
         $error("dma_channel: CNT_W must lie in 2..32");
      end
      if (ADDR_W < 2 || ADDR_W > 32) begin : g_bad_addr
         $error("dma_channel: ADDR_W must lie in 2..32");
      end
      if (DATA_W < 1) begin : g_bad_data
         $error("dma_channel: DATA_W must be positive");
      end
      if (ITEM_BYTES < 0) begin : g_bad_step
         $error("dma_channel: ITEM_BYTES must not be negative");
      end
   endgenerate

   logic [CTRL_W-1:0] ctrl;
   logic [ADDR_W-1:0] paddr, maddr, ptr_p, ptr_m;
   logic [FLAG_W-1:0] flags;
   logic [CNT_W-1:0]  cnt;
   logic              en_rise, cnt_we, cnt_zero, wrap, tc_evt, ht_evt;
   logic              xfer_done, xfer_err;

   dma_ch_regs #(.ADDR_W(ADDR_W)) u_regs (
      .clk       (clk),
      .rst_n     (rst_n),
      .reg_we    (reg_we),
      .reg_addr  (reg_addr),
      .reg_wdata (reg_wdata),
      .err_evt   (xfer_err),
      .tc_evt    (tc_evt),
      .ht_evt    (ht_evt),
      .ctrl_o    (ctrl),
      .paddr_o   (paddr),
      .maddr_o   (maddr),
      .flags_o   (flags),
      .en_rise_o (en_rise),
      .cnt_we_o  (cnt_we)
   );

   dma_ch_counter #(.CNT_W(CNT_W)) u_count (
      .clk        (clk),
      .rst_n      (rst_n),
      .load_i     (cnt_we),
      .load_val_i (reg_wdata[CNT_W-1:0]),
      .done_i     (xfer_done),
      .circ_i     (ctrl[CB_CIRC]),
      .cnt_o      (cnt),
      .zero_o     (cnt_zero),
      .wrap_o     (wrap),
      .tc_evt_o   (tc_evt),
      .ht_evt_o   (ht_evt)
   );

   dma_ch_addr_gen #(.ADDR_W(ADDR_W), .STEP(ITEM_BYTES)) u_pptr (
      .clk    (clk),
      .rst_n  (rst_n),
      .base_i (paddr),
      .load_i (en_rise),
      .wrap_i (wrap),
      .adv_i  (xfer_done && ctrl[CB_PINC]),
      .ptr_o  (ptr_p)
   );

   dma_ch_addr_gen #(.ADDR_W(ADDR_W), .STEP(ITEM_BYTES)) u_mptr (
      .clk    (clk),
      .rst_n  (rst_n),
      .base_i (maddr),
      .load_i (en_rise),
      .wrap_i (wrap),
      .adv_i  (xfer_done && ctrl[CB_MINC]),
      .ptr_o  (ptr_m)
   );

   dma_ch_xfer_fsm #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_fsm (
      .clk        (clk),
      .rst_n      (rst_n),
      .en_i       (ctrl[CB_EN]),
      .dir_i      (ctrl[CB_DIR]),
      .cnt_zero_i (cnt_zero),
      .periph_req (periph_req),
      .ptr_p_i    (ptr_p),
      .ptr_m_i    (ptr_m),
      .bus_gnt    (bus_gnt),
      .bus_err    (bus_err),
      .bus_rdata  (bus_rdata),
      .bus_req    (bus_req),
      .bus_we     (bus_we),
      .bus_addr   (bus_addr),
      .bus_wdata  (bus_wdata),
      .done_o     (xfer_done),
      .err_o      (xfer_err)
   );

   always_comb begin
      unique case (reg_addr)
         RA_CTRL:  reg_rdata = 32'(ctrl);
         RA_COUNT: reg_rdata = 32'(cnt);
         RA_PADDR: reg_rdata = 32'(paddr);
         RA_MADDR: reg_rdata = 32'(maddr);
         RA_FLAGS: reg_rdata = 32'(flags);
         default:  reg_rdata = '0;
      endcase
   end

   assign periph_ack = xfer_done;
   assign irq_tc     = flags[FB_TC] && ctrl[CB_TCIE];
   assign irq_ht     = flags[FB_HT] && ctrl[CB_HTIE];
   assign irq_te     = flags[FB_TE] && ctrl[CB_TEIE];

   a_r5_locked_count: assert property (@(posedge clk) disable iff (!rst_n)
      (ctrl[CB_EN] && !xfer_done) |=> $stable(cnt));

   a_r4_ack_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
      (!ctrl[CB_EN] && !bus_req) |=> !periph_ack);

endmodule

// File: tb/sim_dma_channel.sv
module sim_dma_channel;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        d_we = 1'b0;
   logic [2:0]  d_addr = '0;
   logic [31:0] d_wd = '0;
   logic        d_preq = 1'b0;
   logic        d_gnt = 1'b0;
   logic        d_err = 1'b0;
   logic [31:0] d_rdata = '0;

   logic [31:0] reg_rdata, bus_addr, bus_wdata;
   logic        periph_ack, bus_req, bus_we, irq_tc, irq_ht, irq_te;

   always #10 clk = ~clk;

   dma_channel u0 (
      .clk(clk), .rst_n(rst_n),
      .reg_we(d_we), .reg_addr(d_addr), .reg_wdata(d_wd), .reg_rdata(reg_rdata),
      .periph_req(d_preq), .periph_ack(periph_ack),
      .bus_req(bus_req), .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
      .bus_rdata(d_rdata), .bus_gnt(d_gnt), .bus_err(d_err),
      .irq_tc(irq_tc), .irq_ht(irq_ht), .irq_te(irq_te)
   );

   int n_cmp = 0, n_bad = 0, n_ack = 0;
   bit finished = 0;

   // stimulus requests, applied at the next falling edge
   logic        s_we = 0;
   logic [2:0]  s_addr = 0;
   logic [31:0] s_wd = 0;
   logic        s_preq = 0;
   int          lat = 0;
   int          wcnt = 0;
   bit          err_arm = 0;
   logic [31:0] err_addr = 0;
   logic [31:0] last_rd;

   // behavioural reference state
   logic [7:0]  m_ctrl = 0;
   logic [2:0]  m_flags = 0;
   int          m_cnt = 0, m_prog = 0, m_st = 0;
   logic [31:0] m_pa = 0, m_ma = 0, m_pp = 0, m_mp = 0, m_data = 0;

   function automatic logic [31:0] m_read(input logic [2:0] a);
      case (a)
         3'd0: return {24'b0, m_ctrl};
         3'd1: return 32'(m_cnt);
         3'd2: return m_pa;
         3'd3: return m_ma;
         3'd4: return {29'b0, m_flags};
         default: return 32'b0;
      endcase
   endfunction

   task automatic cmp(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
      end
   endtask

   task automatic tick();
      logic [31:0] src, dst, nw;
      bit done, errv, tc, ht, wrap, swc, rise;
      @(negedge clk);
      src = m_ctrl[4] ? m_mp : m_pp;
      dst = m_ctrl[4] ? m_pp : m_mp;
      cmp("R2 bus_req", {31'b0, bus_req}, {31'b0, m_st != 0});
      if (m_st != 0) begin
         cmp("R2 bus_we", {31'b0, bus_we}, {31'b0, m_st == 2});
         cmp("R3 bus_addr", bus_addr, (m_st == 2) ? dst : src);
      end
      if (m_st == 2) cmp("R2 bus_wdata", bus_wdata, m_data);
      cmp("R10 irq_tc", {31'b0, irq_tc}, {31'b0, m_flags[0] & m_ctrl[1]});
      cmp("R10 irq_ht", {31'b0, irq_ht}, {31'b0, m_flags[1] & m_ctrl[2]});
      cmp("R10 irq_te", {31'b0, irq_te}, {31'b0, m_flags[2] & m_ctrl[3]});
      // bus responder and register port
      d_gnt   = bus_req && (wcnt >= lat);
      d_err   = d_gnt && err_arm && (bus_addr == err_addr);
      d_rdata = bus_addr ^ 32'hC3C3_0000;
      d_we = s_we; d_addr = s_addr; d_wd = s_wd; d_preq = s_preq;
      #1;
      done = (m_st == 2) && d_gnt && !d_err;
      errv = (m_st != 0) && d_gnt && d_err;
      cmp("R4 periph_ack", {31'b0, periph_ack}, {31'b0, done});
      if (periph_ack) n_ack++;
      last_rd = reg_rdata;
      case (s_addr)
         3'd0: cmp("R1 ctrl read", reg_rdata, m_read(s_addr));
         3'd1: cmp("R5 count read", reg_rdata, m_read(s_addr));
         3'd4: cmp("R10 flag read", reg_rdata, m_read(s_addr));
         default: cmp("R3 address read", reg_rdata, m_read(s_addr));
      endcase
      // reference next state
      tc   = done && (m_cnt == 1);
      wrap = tc && m_ctrl[5];
      ht   = done && (m_cnt * 2 > m_prog) && ((m_cnt - 1) * 2 <= m_prog);
      swc  = s_we && (s_addr == 3'd1) && !m_ctrl[0];
      rise = s_we && (s_addr == 3'd0) && s_wd[0] && !m_ctrl[0];
      if (rise || wrap) begin
         m_pp = m_pa; m_mp = m_ma;
      end else if (done) begin
         if (m_ctrl[6]) m_pp = m_pp + 4;
         if (m_ctrl[7]) m_mp = m_mp + 4;
      end
      if (swc) begin
         m_cnt = int'(s_wd[15:0]); m_prog = m_cnt;
      end else if (wrap) m_cnt = m_prog;
      else if (done) m_cnt = m_cnt - 1;
      if (m_st == 1 && d_gnt && !d_err) m_data = d_rdata;
      case (m_st)
         0: if (m_ctrl[0] && m_cnt_nz() && s_preq) m_st = 1;
         1: if (d_gnt) m_st = d_err ? 0 : 2;
         default: if (d_gnt) m_st = 0;
      endcase
      if (s_we) begin
         case (s_addr)
            3'd0: m_ctrl = s_wd[7:0];
            3'd2: m_pa = s_wd;
            3'd3: m_ma = s_wd;
            3'd4: m_flags = m_flags & ~s_wd[2:0];
            default: ;
         endcase
      end
      if (tc) m_flags[0] = 1;
      if (ht) m_flags[1] = 1;
      if (errv) begin m_flags[2] = 1; m_ctrl[0] = 0; end
      if (bus_req && !d_gnt) wcnt++; else wcnt = 0;
      if (d_err) err_arm = 0;
      nw = 0;
      @(posedge clk);
   endtask

   // start decision uses the count before this cycle's update
   int pre_cnt;
   function automatic bit m_cnt_nz();
      return pre_cnt != 0;
   endfunction

   task automatic step();
      pre_cnt = m_cnt;
      tick();
   endtask

   task automatic ticks(input int n);
      for (int i = 0; i < n; i++) step();
   endtask

   task automatic wr(input logic [2:0] a, input logic [31:0] v);
      s_we = 1; s_addr = a; s_wd = v;
      step();
      s_we = 0;
   endtask

   task automatic expect_reg(input logic [2:0] a, input logic [31:0] v, input string tag);
      s_addr = a;
      step();
      cmp(tag, last_rd, v);
   endtask

   task automatic wait_acks(input int target);
      for (int g = 0; g < 2000 && n_ack < target; g++) step();
   endtask

   initial begin
      int a0;
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1;
      // R1: reset values
      for (int r = 0; r < 5; r++) expect_reg(3'(r), 32'h0, "R1 reset");

      // non-circular, peripheral to memory, memory increments
      wr(3'd2, 32'h4000_0000);
      wr(3'd3, 32'h2000_0100);
      wr(3'd1, 32'd4);
      wr(3'd0, 32'h87);
      expect_reg(3'd0, 32'h87, "R1 ctrl bits");
      wr(3'd1, 32'd9);
      expect_reg(3'd1, 32'd4, "R5 count locked");
      s_addr = 3'd1;
      a0 = n_ack;
      s_preq = 1;
      wait_acks(a0 + 2);
      s_preq = 0;
      expect_reg(3'd1, 32'd2, "R6 decrement");
      s_addr = 3'd1;
      s_preq = 1;
      ticks(20);
      expect_reg(3'd1, 32'd0, "R6 reached zero");
      expect_reg(3'd4, 32'd3, "R10 half and complete");
      a0 = n_ack;
      ticks(10);
      cmp("R8 no transfer after zero", 32'(n_ack - a0), 32'd0);
      expect_reg(3'd0, 32'h87, "R8 still enabled");
      s_preq = 0;
      ticks(3);
      wr(3'd4, 32'h7);
      expect_reg(3'd4, 32'd0, "R10 clear");
      wr(3'd0, 32'h0);

      // circular, memory to peripheral, peripheral increments, bus waits
      lat = 2;
      wr(3'd2, 32'h4000_0800);
      wr(3'd3, 32'h2000_0400);
      wr(3'd1, 32'd3);
      wr(3'd0, 32'h73);
      s_addr = 3'd1;
      a0 = n_ack;
      s_preq = 1;
      wait_acks(a0 + 3);
      s_preq = 0;
      expect_reg(3'd1, 32'd3, "R7 count reloaded");
      expect_reg(3'd0, 32'h73, "R7 still enabled");
      expect_reg(3'd4, 32'd3, "R10 flags in circular");
      s_preq = 1;
      s_addr = 3'd4;
      wait_acks(a0 + 5);
      s_preq = 0;
      expect_reg(3'd1, 32'd1, "R7 second pass");
      ticks(3);
      wr(3'd0, 32'h0);
      wr(3'd4, 32'h7);

      // bus error on the second write
      lat = 1;
      wr(3'd2, 32'h4000_0010);
      wr(3'd3, 32'h2000_0200);
      wr(3'd1, 32'd5);
      err_addr = 32'h2000_0204;
      err_arm = 1;
      wr(3'd0, 32'hC9);
      s_preq = 1;
      ticks(30);
      s_preq = 0;
      expect_reg(3'd0, 32'hC8, "R9 enable cleared");
      expect_reg(3'd1, 32'd4, "R9 count kept");
      expect_reg(3'd4, 32'd4, "R10 error flag");
      wr(3'd4, 32'h4);

      // no transfer while disabled or with zero count
      lat = 0;
      wr(3'd1, 32'd2);
      a0 = n_ack;
      s_preq = 1;
      ticks(10);
      cmp("R4 disabled channel idle", 32'(n_ack - a0), 32'd0);
      s_preq = 0;
      wr(3'd1, 32'd0);
      wr(3'd0, 32'h1);
      s_preq = 1;
      ticks(10);
      cmp("R4 zero count idle", 32'(n_ack - a0), 32'd0);
      expect_reg(3'd1, 32'd0, "R4 count still zero");
      s_preq = 0;
      ticks(2);

      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!finished) begin
         n_bad++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

endmodule